// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave for a Clock Generator

This block is the serial control port of a multi-output clock generator. It watches the two wires of an SMBus-style bus, oversampled by a faster system clock, and finds start, repeated start and stop conditions. It answers one fixed 7-bit address. Behind that address sits a bank of eight 8-bit configuration registers, and the block decodes four kinds of transfer against that bank: an indexed single-byte write, an indexed single-byte read, a sequential block write that carries a byte count, and a sequential block read that returns a byte count.

Six register bits leave the block as control signals for the rest of the chip: one enable for each of four clock outputs, a spread-spectrum on/off bit and a spread-depth select. The data wire is modelled as an open-drain pull-down enable. The slave pulls the line only during its acknowledge slots and while it shifts out read data, and it changes the line only while the clock wire is low.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: After reset the eight registers read back, from offset 0 upward, as 0x7C, 0x00, 0xEA, 0x00, 0x00, 0x00, 0x13, 0x1F.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 0x69 (0xD2 for a write, 0xD3 for a read). For any other address it does not acknowledge, and it ignores the rest of that transfer until the next start.
- R3: A command byte with bit 7 set selects a single-byte access at the register offset in bits 6:0. A data byte that follows in the same write transfer is stored at that offset. All bytes are sent most significant bit first.
- R4: A single-byte read is address+W, indexed command, repeated start, address+R. The slave then returns the addressed register, most significant bit first.
- R5: A command byte of 0x00 selects a block transfer. In a block write the byte after the command is a count, and the data bytes that follow go to registers 0, 1, 2 and upward. Bytes beyond the count are acknowledged and dropped.
- R6: A block read (command 0x00, repeated start, address+R) returns first a count byte of 8 and then the registers in ascending order. It stops when the master answers a byte with NACK, and it may stop after any byte.
- R7: Register 7 is read-only and keeps 0x1F. A write to an offset of 8 or more is acknowledged and discarded. A read from such an offset returns 0x00.
- R8: Register 0 bits 6,5,4,3 drive output enables 3,2,1,0 (1 = enabled). Register 2 bit 2 drives the spread enable and bit 7 drives the spread-depth select (1 = deeper spread).
- R9: The control outputs change only after all eight bits of a data byte have been received, never partway through a byte.
- R10: The slave pulls SDA only in its acknowledge slots and during read-data bits. It changes SDA only while SCL is low, and it has released SDA after a stop.
- R11: A block write that the master ends with a stop after fewer data bytes than its count updates only the registers it reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock wire as seen at the pin |
| sda_i | input | 1 | Serial data wire as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data wire low (open-drain) |
| out_en | output | 4 | Per-output clock enables, bit n for output n |
| spread_en | output | 1 | Spread-spectrum on |
| spread_deep | output | 1 | Spread-depth select, 1 = deeper setting |

## Verification
The bench drives all four transfer types with data patterns whose bits differ from the defaults. A block read of the reset values separates a correct byte order and count byte from a shifted or reversed one. A block write with more data bytes than its count, and another cut short by a stop, separate count-limited and stop-limited storage from plain sequential writing. Foreign addresses, the read-only register and offsets past the bank show whether the ignored cases really leave the registers untouched. The output enables are sampled after seven bits and again after the eighth, which exposes any update made partway through a byte.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK_PRE, S_ACK, S_TX, S_TX_ACK, S_TX_NEXT, S_SKIP
  } bus_state_t;

  typedef enum logic [1:0] {
    P_ADDR, P_CMD, P_CNT, P_DATA
  } rx_phase_t;

  // Power-up value of each register in the bank.
  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h7C;
      2:       return 8'hEA;
      6:       return 8'h13;
      7:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  // The topmost register holds the identity code and cannot be written.
  function automatic logic reg_is_writable(input int unsigned idx, input int unsigned nregs);
    return idx < nregs - 1;
  endfunction

  // The register pointer stops at its top value instead of wrapping into the bank.
  function automatic logic [7:0] ptr_step(input logic [7:0] p);
    return (p == 8'hFF) ? p : p + 8'd1;
  endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
`timescale 1ns/1ps
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] pins;
  logic [1:0] synced;
  logic [1:0] prev;

  assign pins = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pins[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign scl_rise = scl_s & ~prev[0];
  assign scl_fall = ~scl_s & prev[0];
  assign start_ev = scl_s & prev[0] & prev[1] & ~sda_s;
  assign stop_ev  = scl_s & prev[0] & ~prev[1] & sda_s;
endmodule

// File: rtl/clkcfg_regbank.sv
`timescale 1ns/1ps
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [3:0] out_en,
  output logic       spread_en,
  output logic       spread_deep
);
  localparam int         IW  = $clog2(NREGS);
  localparam logic [7:0] NR8 = 8'(NREGS);

  logic [NREGS*8-1:0] flat;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (reg_is_writable(g, NREGS)) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= reg_default(g);
        else if (wr_stb && wr_idx == 8'(g))  q <= wr_data;
      end
      assign flat[g*8 +: 8] = q;
    end else begin : g_ro
      assign flat[g*8 +: 8] = reg_default(g);
    end
  end

  assign rd_data     = (rd_idx < NR8) ? flat[{rd_idx[IW-1:0], 3'b000} +: 8] : 8'h00;
  assign out_en      = flat[6:3];
  assign spread_en   = flat[16 + 2];
  assign spread_deep = flat[16 + 7];

  // R9: the control outputs move only on a write strobe
  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({out_en, spread_en, spread_deep}));
endmodule

// File: rtl/clkcfg_protocol.sv
`timescale 1ns/1ps
module clkcfg_protocol
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         NREGS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx
);
  localparam logic [7:0] CNT_BYTE = 8'(NREGS);

  bus_state_t st;
  rx_phase_t  phase;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] ptr;
  logic [7:0] remain;
  logic       blk;
  logic       reading;
  logic       cnt_sent;

  logic [7:0] rx_byte;
  logic       byte_done;
  logic [7:0] tx_next;
  logic       tx_is_cnt;

  assign rx_byte   = {shreg[6:0], sda_s};
  assign byte_done = (st == S_RX) && scl_rise && (bitcnt == 3'd7);
  assign wr_stb    = byte_done && (phase == P_DATA) && (!blk || remain != 8'd0);
  assign wr_idx    = ptr;
  assign wr_data   = rx_byte;
  assign rd_idx    = ptr;
  assign tx_is_cnt = blk && !cnt_sent;
  assign tx_next   = tx_is_cnt ? CNT_BYTE : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= P_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      remain   <= '0;
      blk      <= 1'b0;
      reading  <= 1'b0;
      cnt_sent <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      st       <= S_RX;
      phase    <= P_ADDR;
      bitcnt   <= '0;
      reading  <= 1'b0;
      cnt_sent <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: if (scl_rise) begin
          shreg  <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            st <= S_ACK_PRE;
            case (phase)
              P_ADDR: begin
                if (rx_byte[7:1] == ADDR7) begin
                  reading <= rx_byte[0];
                  phase   <= P_CMD;
                end else begin
                  st <= S_SKIP;
                end
              end
              P_CMD: begin
                blk   <= ~rx_byte[7];
                ptr   <= rx_byte[7] ? {1'b0, rx_byte[6:0]} : 8'd0;
                phase <= rx_byte[7] ? P_DATA : P_CNT;
              end
              P_CNT: begin
                remain <= rx_byte;
                phase  <= P_DATA;
              end
              default: begin
                if (blk && remain != 8'd0) remain <= remain - 8'd1;
                ptr <= ptr_step(ptr);
              end
            endcase
          end
        end
        S_ACK_PRE: if (scl_fall) begin
          sda_oe <= 1'b1;
          st     <= S_ACK;
        end
        S_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (reading) begin
            shreg  <= tx_next;
            sda_oe <= ~tx_next[7];
            st     <= S_TX;
            if (tx_is_cnt) cnt_sent <= 1'b1;
            else           ptr      <= ptr_step(ptr);
          end else begin
            sda_oe <= 1'b0;
            st     <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0;
            st     <= S_TX_ACK;
          end else begin
            sda_oe <= ~shreg[6];
            shreg  <= {shreg[6:0], 1'b0};
            bitcnt <= bitcnt + 3'd1;
          end
        end
        S_TX_ACK: if (scl_rise) begin
          st <= sda_s ? S_SKIP : S_TX_NEXT;
        end
        S_TX_NEXT: if (scl_fall) begin
          bitcnt <= '0;
          shreg  <= tx_next;
          sda_oe <= ~tx_next[7];
          st     <= S_TX;
          if (tx_is_cnt) cnt_sent <= 1'b1;
          else           ptr      <= ptr_step(ptr);
        end
        default: ;
      endcase
    end
  end

  // R10: the pull-down is on only in an acknowledge slot or a read-data bit
  a_r10_pull_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACK || st == S_TX));

  // R10: the slave moves SDA only while the synchronised clock wire is low
  a_r10_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R9: register writes happen at the sampling edge of the eighth bit
  a_r9_write_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> scl_s);

  // R2: a start condition leaves the line released
  a_r2_start_released: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
endmodule

// File: rtl/clkcfg_smbus_slave.sv
`timescale 1ns/1ps
module clkcfg_smbus_slave #(
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         NREGS       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [3:0] out_en,
  output logic       spread_en,
  output logic       spread_deep
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_stb;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  clkcfg_protocol #(.ADDR7(ADDR7), .NREGS(NREGS)) u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx)
  );

  clkcfg_regbank #(.NREGS(NREGS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .out_en      (out_en),
    .spread_en   (spread_en),
    .spread_deep (spread_deep)
  );
endmodule

// File: tb/test_clkcfg_smbus_slave.sv
`timescale 1ns/1ps
module test_clkcfg_smbus_slave;
  localparam int Q = 8;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [3:0] out_en;
  logic spread_en, spread_deep;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkcfg_smbus_slave i_clkcfg_smbus_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .out_en(out_en), .spread_en(spread_en), .spread_deep(spread_deep)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_ack(output logic a);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); a = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    get_ack(a);
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~m_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; sda_m = 1'b1; wq();
  endtask

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: return 8'h7C; 2: return 8'hEA; 6: return 8'h13; 7: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic byte_write(input string tag, input logic [6:0] off, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk({tag, " addr ack"}, a, 1);
    send_byte({1'b1, off}, a); chk({tag, " cmd ack"}, a, 1);
    send_byte(d, a); chk({tag, " data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic byte_read(input string tag, input logic [6:0] off, input logic [7:0] exp);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a);
    send_byte({1'b1, off}, a);
    bus_start();
    send_byte(8'hD3, a); chk({tag, " read addr ack"}, a, 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk({tag, " read data"}, d, exp);
  endtask

  // R1 R8: reset state at the outputs
  task automatic t_reset();
    chk("R1 R8 out_en reset", out_en, 4'hF);
    chk("R8 spread_en reset", spread_en, 0);
    chk("R8 spread_deep reset", spread_deep, 1);
    chk("R10 sda released at reset", sda_oe, 0);
  endtask

  // R6 R1: full block read of the power-up contents
  task automatic t_block_read_defaults();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a); chk("R6 addr ack", a, 1);
    send_byte(8'h00, a); chk("R6 cmd ack", a, 1);
    bus_start();
    send_byte(8'hD3, a); chk("R6 read addr ack", a, 1);
    recv_byte(1'b1, d); chk("R6 count byte", d, 8);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, d);
      chk($sformatf("R1 default reg%0d", i), d, dflt(i));
    end
    bus_stop();
    chk("R10 released after stop", sda_oe, 0);
  endtask

  // R3 R8 R9: single-byte writes with a mid-byte look at the outputs
  task automatic t_byte_write();
    logic a;
    logic [7:0] v = 8'h28;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h80, a); chk("R3 cmd ack", a, 1);
    for (int i = 7; i >= 1; i--) bit_out(v[i]);
    chk("R9 out_en unchanged after 7 bits", out_en, 4'hF);
    bit_out(v[0]);
    get_ack(a); chk("R3 data ack", a, 1);
    bus_stop();
    chk("R8 R9 out_en after byte", out_en, 4'b0101);
    byte_write("R3 reg2", 7'd2, 8'h04);
    chk("R8 spread_en from reg2 bit2", spread_en, 1);
    chk("R8 spread_deep from reg2 bit7", spread_deep, 0);
  endtask

  // R4: indexed reads through repeated start
  task automatic t_byte_read();
    byte_read("R4 reg0", 7'd0, 8'h28);
    byte_read("R4 reg6", 7'd6, 8'h13);
    byte_read("R4 reg2", 7'd2, 8'h04);
  endtask

  // R2: foreign addresses are not acknowledged and change nothing
  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hA4, a); chk("R2 foreign addr nack", a, 0);
    send_byte(8'h80, a);
    send_byte(8'hFF, a);
    bus_stop();
    bus_start();
    send_byte(8'hD0, a); chk("R2 near addr nack", a, 0);
    send_byte(8'h80, a);
    send_byte(8'h00, a);
    bus_stop();
    chk("R2 out_en untouched", out_en, 4'b0101);
    byte_read("R2 reg0 untouched", 7'd0, 8'h28);
  endtask

  // R7: read-only identity register and offsets past the bank
  task automatic t_readonly();
    byte_write("R7 reg7", 7'd7, 8'h55);
    byte_read("R7 reg7 kept", 7'd7, 8'h1F);
    byte_write("R7 off16", 7'h10, 8'hAB);
    byte_read("R7 off16 reads zero", 7'h10, 8'h00);
    byte_read("R7 reg0 after off16", 7'd0, 8'h28);
  endtask

  task automatic block_write(input string tag, input logic [7:0] cnt, input int n, input logic [7:0] base);
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(cnt, a); chk({tag, " count ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i * 8'h29), a);
      chk($sformatf("%s data%0d ack", tag, i), a, 1);
    end
    bus_stop();
  endtask

  // R5 R8: block write with one byte more than its count
  task automatic t_block_write();
    // data bytes: 0x41, 0x6A, 0x93, 0xBC
    block_write("R5", 8'd3, 4, 8'h41);
    byte_read("R5 reg0", 7'd0, 8'h41);
    byte_read("R5 reg1", 7'd1, 8'h6A);
    byte_read("R5 reg2", 7'd2, 8'h93);
    byte_read("R5 reg3 beyond count", 7'd3, 8'h00);
    chk("R8 out_en from 0x41", out_en, 4'b1000);
    chk("R8 spread_en from 0x93", spread_en, 0);
    chk("R8 spread_deep from 0x93", spread_deep, 1);
  endtask

  // R11 R6: block write cut short, block read cut short
  task automatic t_block_early();
    logic a;
    logic [7:0] d;
    block_write("R11", 8'd8, 1, 8'h7C);
    byte_read("R11 reg0", 7'd0, 8'h7C);
    byte_read("R11 reg1 untouched", 7'd1, 8'h6A);
    chk("R11 out_en", out_en, 4'hF);
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, d); chk("R6 partial count", d, 8);
    recv_byte(1'b1, d); chk("R6 partial reg0", d, 8'h7C);
    recv_byte(1'b0, d); chk("R6 partial reg1", d, 8'h6A);
    bus_stop();
    chk("R10 released after partial read", sda_oe, 0);
    byte_read("R6 bus usable after partial", 7'd6, 8'h13);
  endtask

  // R5 R7: block write running past the end of the bank
  task automatic t_block_overrun();
    // data bytes 0x10 + 0x29*i
    block_write("R5 overrun", 8'd10, 10, 8'h10);
    byte_read("R5 overrun reg0", 7'd0, 8'h10);
    byte_read("R5 overrun reg6", 7'd6, 8'(8'h10 + 6 * 8'h29));
    byte_read("R7 overrun reg7 kept", 7'd7, 8'h1F);
    chk("R8 out_en from 0x10", out_en, 4'b0010);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_block_read_defaults();
    t_byte_write();
    t_byte_read();
    t_wrong_addr();
    t_readonly();
    t_block_write();
    t_block_early();
    t_block_overrun();
    done = 1'b1;
    finish_run();
  end
endmodule